// File: doc/BRIEF.md
# Windowed Physical Address Translator

This block turns a 36-bit physical address into a 30-bit DDR address and a channel number. It does this through four address windows, each programmed on its own. Every window stores five things: a lower bound, an upper bound, an offset, a channel select and an enable. The bounds and the offset are kept at 1 MB granularity.

An incoming address falls inside a window when it lies between the start of the window's lower 1 MB block and the end of its upper 1 MB block, both ends included. For the winning window, the translated address is the incoming address minus the window base plus the window offset.

The translation path is purely combinational, from `epa` to `hit`, `ddr_addr` and `ddr_chan`. Window settings are written through a plain indexed register port with one 64-bit word per window. A write takes effect at the next rising clock edge. The read data reflects the window currently selected by `reg_idx`.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every window word reads zero, and `hit` is low for any address.
- R2: A window matches when it is enabled and (lower << 20) <= epa <= ((upper << 20) | 0xFFFFF). Both ends are inclusive.
- R3: On a hit, `ddr_addr` equals (epa − (lower << 20) + (offset << 20)) modulo 2^30. Any carry above bit 29 is dropped.
- R4: The channel select field maps values 0 and 1 to `ddr_chan` = 0, and values 2 and 3 to `ddr_chan` = 1.
- R5: When several enabled windows match, the lowest-numbered one decides the address and the channel.
- R6: A window with its enable bit at 0 never matches, whatever its bounds.
- R7: When no window matches, `hit`, `ddr_addr` and `ddr_chan` are all zero.
- R8: Word bits 61:56 read back lower-bound bits 15:10 (address bits 35:30). Writes to these bits are ignored.
- R9: Word bits 63:62, 55:49, 47:46 and 43:42 are reserved. They read as zero whatever was written.
- R10: A write to one window leaves the other windows' words unchanged.
- R11: The word layout is as follows: lower bound in bits 15:0, upper bound in 31:16, offset in 41:32, channel select in 45:44 and enable in bit 48. A written word reads back, after the next clock edge, with those fields intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the window word |
| reg_idx | input | 2 | Window index for write and read |
| reg_wdata | input | 64 | Window word to write |
| reg_rdata | output | 64 | Window word of the selected index |
| epa | input | 36 | Physical address to translate |
| hit | output | 1 | An enabled window matches |
| ddr_addr | output | 30 | Translated DDR address |
| ddr_chan | output | 1 | DDR channel of the match |

## Verification
Addresses are placed on both edges of each window: the first byte of the lower block, the last byte of the upper block, and one byte outside on either side. These separate inclusive from exclusive compares, and ones-fill from zero-fill of the upper bound. An address in the overlap of window 0 and window 1 shows whether the priority order is right. The topmost address in window 2 forces a carry out of the 30-bit sum, so it shows whether the carry is dropped. An address inside a disabled window, before and after that window is enabled, shows whether the enable bit gates the match. Words of all ones and words with a junk mirror field show the masking of the mirror bits and of the reserved bits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int PA_W    = 36;
   localparam int GRAN_W  = 20;
   localparam int OUT_W   = 30;
   localparam int REG_W   = 64;
   localparam int SEL_W   = 2;
   localparam int MIR_W   = 6;
   localparam int LB_W    = PA_W - GRAN_W;
   localparam int OF_W    = OUT_W - GRAN_W;

   localparam int LO_LSB  = 0;
   localparam int UP_LSB  = 16;
   localparam int OF_LSB  = 32;
   localparam int SEL_LSB = 44;
   localparam int EN_BIT  = 48;
   localparam int MIR_LSB = 56;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
      logic [OF_W-1:0]  off;
      logic [LB_W-1:0]  up;
      logic [LB_W-1:0]  lo;
   } win_cfg_t;

   function automatic logic [REG_W-1:0] pack_win(input win_cfg_t c);
      logic [REG_W-1:0] r;
      r                        = '0;
      r[LO_LSB +: LB_W]        = c.lo;
      r[UP_LSB +: LB_W]        = c.up;
      r[OF_LSB +: OF_W]        = c.off;
      r[SEL_LSB +: SEL_W]      = c.sel;
      r[EN_BIT]                = c.en;
      r[MIR_LSB +: MIR_W]      = c.lo[LB_W-1 -: MIR_W];
      return r;
   endfunction

   function automatic win_cfg_t unpack_win(input logic [REG_W-1:0] w);
      win_cfg_t c;
      c.lo  = w[LO_LSB +: LB_W];
      c.up  = w[UP_LSB +: LB_W];
      c.off = w[OF_LSB +: OF_W];
      c.sel = w[SEL_LSB +: SEL_W];
      c.en  = w[EN_BIT];
      return c;
   endfunction

   localparam logic [REG_W-1:0] RD_MASK = pack_win('1);
   localparam logic [REG_W-1:0] WR_MASK =
      RD_MASK & ~({{(REG_W-MIR_W){1'b0}}, {MIR_W{1'b1}}} << MIR_LSB);

endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
   import xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   localparam int IDX_W  = $clog2(NUM_WIN)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [REG_W-1:0]         wdata_i,
   output logic [REG_W-1:0]         rdata_o,
   output win_cfg_t [NUM_WIN-1:0]   cfg_o
);

   win_cfg_t [NUM_WIN-1:0] win_q;
   logic     [NUM_WIN-1:0] wsel;
   win_cfg_t               wcfg;

   if (NUM_WIN < 2) begin : g_bad_num
      $error("xlat_win_regs: NUM_WIN must be at least 2");
   end
   if (LB_W < MIR_W) begin : g_bad_mir
      $error("xlat_win_regs: bound field narrower than mirror field");
   end

   assign wcfg = unpack_win(wdata_i);

   logic unused_wdata;
   assign unused_wdata = ^(wdata_i & ~WR_MASK);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      assign wsel[i] = wr_i && (idx_i == IDX_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            win_q[i] <= '0;
         end else if (wsel[i]) begin
            win_q[i] <= wcfg;
         end
      end

      // R10
      other_win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wsel[i] |=> $stable(win_q[i]));

      // R11
      write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wsel[i] |=> (pack_win(win_q[i]) & WR_MASK) == ($past(wdata_i) & WR_MASK));
   end

   if (NUM_WIN == (1 << IDX_W)) begin : g_rd_full
      assign rdata_o = pack_win(win_q[idx_i]);
   end else begin : g_rd_part
      always_comb begin
         rdata_o = '0;
         for (int i = 0; i < NUM_WIN; i++) begin
            if (idx_i == IDX_W'(i)) rdata_o = pack_win(win_q[i]);
         end
      end
   end

   assign cfg_o = win_q;

   // R8
   mirror_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[MIR_LSB +: MIR_W] == rdata_o[LO_LSB + LB_W - MIR_W +: MIR_W]);

   // R9
   reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdata_o & ~RD_MASK) == '0);

endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
   import xlat_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  win_cfg_t          cfg_i,
   input  logic [PA_W-1:0]   epa_i,
   output logic              match_o,
   output logic [OUT_W-1:0]  xaddr_o,
   output logic              chan_o
);

   logic [PA_W-1:0]  lo_full;
   logic [PA_W-1:0]  up_full;
   logic [PA_W-1:0]  diff;
   logic [OUT_W-1:0] off_full;
   logic             in_rng;

   assign lo_full  = {cfg_i.lo, {GRAN_W{1'b0}}};
   assign up_full  = {cfg_i.up, {GRAN_W{1'b1}}};
   assign off_full = {cfg_i.off, {GRAN_W{1'b0}}};

   assign in_rng  = (epa_i >= lo_full) && (epa_i <= up_full);
   assign match_o = cfg_i.en && in_rng;

   assign diff    = epa_i - lo_full;
   assign xaddr_o = diff[OUT_W-1:0] + off_full;
   assign chan_o  = cfg_i.sel[SEL_W-1];

   logic unused_bits;
   assign unused_bits = ^{diff[PA_W-1:OUT_W], cfg_i.sel[SEL_W-2:0]};

   // R3
   low_bits_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o |-> xaddr_o[GRAN_W-1:0] == epa_i[GRAN_W-1:0]);

endmodule

// File: rtl/xlat_prio_sel.sv
module xlat_prio_sel
   import xlat_pkg::*;
#(
   parameter int NUM_WIN   = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_WIN-1:0]             match_i,
   input  logic [NUM_WIN-1:0][OUT_W-1:0]  xaddr_i,
   input  logic [NUM_WIN-1:0]             chan_i,
   output logic                           hit_o,
   output logic [OUT_W-1:0]               addr_o,
   output logic                           chan_o
);

   logic [NUM_WIN-1:0] grant;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         grant = '0;
         for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_i[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         grant = '0;
         for (int i = 0; i < NUM_WIN; i++) begin
            if (match_i[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      addr_o = '0;
      chan_o = 1'b0;
      for (int i = 0; i < NUM_WIN; i++) begin
         addr_o = addr_o | (grant[i] ? xaddr_i[i] : '0);
         chan_o = chan_o | (grant[i] & chan_i[i]);
      end
   end

   assign hit_o = |grant;

   // R5
   one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant));

   // R7
   miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_o |-> (addr_o == '0 && chan_o == 1'b0));

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
      localparam logic [NUM_WIN-1:0] BELOW = NUM_WIN'((64'd1 << i) - 64'd1);
      localparam logic [NUM_WIN-1:0] ABOVE = ~BELOW & ~NUM_WIN'(64'd1 << i);

      // R2
      grant_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         grant[i] |-> match_i[i]);

      // R5
      lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         grant[i] |-> ((match_i & (LOW_FIRST ? BELOW : ABOVE)) == '0));
   end

endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
   import xlat_pkg::*;
#(
   parameter int  NUM_WIN   = 4,
   parameter bit  LOW_FIRST = 1'b1,
   localparam int IDX_W     = $clog2(NUM_WIN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [IDX_W-1:0]   reg_idx,
   input  logic [63:0]        reg_wdata,
   output logic [63:0]        reg_rdata,
   input  logic [35:0]        epa,
   output logic               hit,
   output logic [29:0]        ddr_addr,
   output logic               ddr_chan
);

   if (REG_W != 64 || PA_W != 36 || OUT_W != 30) begin : g_bad_w
      $error("addr_window_xlat: package widths do not fit the port list");
   end

   win_cfg_t [NUM_WIN-1:0]            cfg;
   logic     [NUM_WIN-1:0]            match;
   logic     [NUM_WIN-1:0][OUT_W-1:0] xaddr;
   logic     [NUM_WIN-1:0]            chan;

   xlat_win_regs #(.NUM_WIN(NUM_WIN)) i_regs (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .wr_i    (reg_wr),
      .idx_i   (reg_idx),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .cfg_o   (cfg)
   );

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      xlat_win_match i_match (
         .clk_i   (clk),
         .rst_ni  (rst_n),
         .cfg_i   (cfg[i]),
         .epa_i   (epa),
         .match_o (match[i]),
         .xaddr_o (xaddr[i]),
         .chan_o  (chan[i])
      );

      // R6
      off_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_rdata[EN_BIT] && (reg_idx == IDX_W'(i)) |-> !match[i]);
   end

   xlat_prio_sel #(.NUM_WIN(NUM_WIN), .LOW_FIRST(LOW_FIRST)) i_sel (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .match_i (match),
      .xaddr_i (xaddr),
      .chan_i  (chan),
      .hit_o   (hit),
      .addr_o  (ddr_addr),
      .chan_o  (ddr_chan)
   );

endmodule

// File: tb/test_addr_window_xlat.sv
module test_addr_window_xlat;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [35:0] epa = '0;
   logic        hit;
   logic [29:0] ddr_addr;
   logic        ddr_chan;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   addr_window_xlat i_addr_window_xlat (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .epa(epa),
      .hit(hit), .ddr_addr(ddr_addr), .ddr_chan(ddr_chan)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // {epa, hit, ddr_addr, ddr_chan}
   localparam int NVEC = 11;
   localparam logic [67:0] VEC [NVEC] = '{
      {36'h0000FFFFF, 1'b0, 30'h00000000, 1'b0},   // R2 below window 0
      {36'h000100000, 1'b1, 30'h10000000, 1'b0},   // R2 first byte of window 0
      {36'h0003FFFFF, 1'b1, 30'h102FFFFF, 1'b0},   // R2 last byte of window 0
      {36'h000250000, 1'b1, 30'h10150000, 1'b0},   // R5 overlap 0/1
      {36'h000400000, 1'b1, 30'h20200000, 1'b1},   // R3 window 1
      {36'h0010FFFFF, 1'b1, 30'h20EFFFFF, 1'b1},   // R2 last byte of window 1
      {36'h001100000, 1'b0, 30'h00000000, 1'b0},   // R7 gap
      {36'h002000000, 1'b0, 30'h00000000, 1'b0},   // R6 disabled window 3
      {36'hFFF000000, 1'b1, 30'h3FF00000, 1'b1},   // R4 window 2 sel 3
      {36'hFFFFFFFFF, 1'b1, 30'h00EFFFFF, 1'b1},   // R3 carry dropped
      {36'hFFEFFFFFF, 1'b0, 30'h00000000, 1'b0}    // R7 below window 2
   };

   function automatic logic [63:0] mk(input logic [15:0] lo, input logic [15:0] up,
                                      input logic [9:0] off, input logic [1:0] sel,
                                      input logic en);
      return {8'h0, 7'h0, en, 2'b0, sel, 2'b0, off, up, lo};
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_win(input logic [1:0] idx, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] idx, input logic [63:0] exp);
      reg_idx = idx;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic xl_chk(input string req, input logic [35:0] a, input logic eh,
                         input logic [29:0] ea, input logic ec);
      @(negedge clk);
      epa = a;
      #1;
      chk({req, " hit"}, {63'h0, hit}, {63'h0, eh});
      chk({req, " addr"}, {34'h0, ddr_addr}, {34'h0, ea});
      chk({req, " chan"}, {63'h0, ddr_chan}, {63'h0, ec});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < 4; i++) rd_chk("R1 reset word", 2'(i), 64'h0);
      xl_chk("R1 reset", 36'h0, 1'b0, 30'h0, 1'b0);

      // R8 R9 all-ones write
      wr_win(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R9 R8 all ones", 2'd3, 64'h3F01_33FF_FFFF_FFFF);
      // R10 other windows untouched
      for (int i = 0; i < 3; i++) rd_chk("R10 untouched", 2'(i), 64'h0);

      // R8 mirror ignores written bits
      wr_win(2'd3, mk(16'h8C00, 16'h8C00, 10'h0, 2'd0, 1'b0) | (64'h15 << 56));
      rd_chk("R8 mirror", 2'd3, mk(16'h8C00, 16'h8C00, 10'h0, 2'd0, 1'b0) | (64'h23 << 56));

      // program windows
      wr_win(2'd0, mk(16'h0001, 16'h0003, 10'h100, 2'd0, 1'b1));
      wr_win(2'd1, mk(16'h0002, 16'h0010, 10'h200, 2'd2, 1'b1));
      wr_win(2'd2, mk(16'hFFF0, 16'hFFFF, 10'h3FF, 2'd3, 1'b1));
      wr_win(2'd3, mk(16'h0020, 16'h0020, 10'h000, 2'd1, 1'b0));
      // R11 readback
      rd_chk("R11 readback w1", 2'd1, mk(16'h0002, 16'h0010, 10'h200, 2'd2, 1'b1));
      rd_chk("R11 readback w2", 2'd2,
             mk(16'hFFF0, 16'hFFFF, 10'h3FF, 2'd3, 1'b1) | (64'h3F << 56));

      for (int v = 0; v < NVEC; v++) begin
         xl_chk($sformatf("R2 R3 R4 R5 R7 vec%0d", v), VEC[v][67:32], VEC[v][31],
                VEC[v][30:1], VEC[v][0]);
      end

      // R6 enable window 3, sel 1 -> channel 0
      wr_win(2'd3, mk(16'h0020, 16'h0020, 10'h000, 2'd1, 1'b1));
      xl_chk("R6 R4 enabled w3", 36'h002000000, 1'b1, 30'h0, 1'b0);
      xl_chk("R2 w3 top", 36'h0020FFFFF, 1'b1, 30'h000FFFFF, 1'b0);

      // R5 window 0 moved to cover window 1 territory; low index wins
      wr_win(2'd0, mk(16'h0004, 16'h0004, 10'h001, 2'd0, 1'b1));
      xl_chk("R5 priority", 36'h000412345, 1'b1, 30'h00112345, 1'b0);

      // R1 reset clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 after reset", 2'd1, 64'h0);
      xl_chk("R1 after reset", 36'h000400000, 1'b0, 30'h0, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule